// File: doc/BRIEF.md
# Iterative AES-128 Round Engine

This block encrypts one 128-bit block with AES-128, working through the cipher one round at a time over a single shared datapath. A load strobe captures the plaintext and applies the first round-key XOR at once. Ten rounds then follow. Each round passes the state through a byte substitution, a row rotation, a column mixing step and a round-key XOR. The last round leaves out the column mixing.

The expanded round keys are not stored here. The engine publishes the number of the round key it needs on `round_idx_o`, and an external key scheduler answers on `round_key_i` in the same cycle. The substitution table is held in a synchronous read-only memory with one cycle of read latency, so each round spends three cycles:
- one to present the addresses,
- one to register the substituted bytes,
- one to rotate, mix, add the key and write the state back.

The result appears on `cipher_o` together with `done_o`. Both stay in place until the next load.

Top module: `aes128_round_engine`

## Requirements
- R1: A load strobe seen while the engine is idle or finished takes `plaintext_i` XOR `round_key_i` as the initial state. `round_idx_o` is 0 at that moment, and it reads 1 in the cycle after the load edge.
- R2: Bits [127:120] of `plaintext_i` form state byte 0. State byte k sits at row k mod 4 and column k div 4. The same byte order applies to `round_key_i` and `cipher_o`.
- R3: `cipher_o` equals the AES-128 ciphertext of the loaded plaintext under the key expanded by the scheduler. Two known vectors must hold:
  - key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32;
  - key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: The row rotation moves row r left by r byte positions, for r from 0 to 3.
- R5: Substitution replaces each of the 16 state bytes with its entry in the 256-entry AES S-box. The S-box is read from a synchronous ROM with a one-cycle read latency.
- R6: In rounds 1 to 9, each column is multiplied by {03}x^3+{01}x^2+{01}x+{02} over GF(2^8), reduced with 0x1B. Round 10 skips this step.
- R7: Each round takes exactly three cycles. In the j-th cycle after the load edge (j = 0..29), `round_idx_o` equals 1 + j div 3. `done_o` rises exactly 30 cycles after the load edge, and `round_idx_o` returns to 0 at the same time.
- R8: `done_o` stays high, and `cipher_o` stays unchanged, until the next load strobe. A load taken while `done_o` is high starts a new operation, and `done_o` is low in the following cycle.
- R9: A load strobe arriving while a block is in progress has no effect. This includes the final round cycle. The running block completes with its original result and timing.
- R10: Active-low asynchronous reset clears `done_o` and `round_idx_o` to 0 and abandons any block in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start strobe; sampled only when not busy |
| plaintext_i | input | 128 | Block to encrypt; byte 0 in bits [127:120] |
| round_key_i | input | 128 | Round key selected by `round_idx_o`, from the key scheduler |
| round_idx_o | output | 4 | Round-key number requested from the scheduler (0 to 10) |
| cipher_o | output | 128 | Ciphertext, valid while `done_o` is high |
| done_o | output | 1 | High from completion until the next load |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is a load strobe and the final round's write-back. The bench raises `load_i` in the last busy cycle, together with a changed plaintext. That strobe must be discarded: the bench requires `done_o` to rise on the 30th cycle and the ciphertext to match its own reference model for the original plaintext.

The second pair is a load strobe and a held `done_o`. The bench loads a new block while the previous result is still displayed. It then requires `done_o` to fall in the next cycle, the round index to restart at 1, and the new result to match the reference model.

// File: rtl/aes_pkg.sv
package aes_pkg;
    localparam int unsigned STATE_BYTES = 16;

    typedef logic [7:0] byte_t;
    // Element 0 is the most significant byte: byte k of the block at row k%4, column k/4.
    typedef logic [0:STATE_BYTES-1][7:0] state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_FETCH,
        PH_ROUND,
        PH_DONE
    } phase_t;

    // Multiply by x in GF(2^8) with the 0x1B reduction.
    function automatic byte_t xtime(input byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t x   = a;
        byte_t y   = b;
        for (int i = 0; i < 8; i++) begin
            if (y[0]) acc = acc ^ x;
            x = xtime(x);
            y = y >> 1;
        end
        return acc;
    endfunction

    // S-box entry: multiplicative inverse (v^254), then the affine map.
    function automatic byte_t sbox_calc(input byte_t v);
        byte_t inv  = 8'h01;
        byte_t base = v;
        byte_t e    = 8'hfe;
        for (int i = 0; i < 8; i++) begin
            if (e[0]) inv = gf_mul(inv, base);
            base = gf_mul(base, base);
            e    = e >> 1;
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/aes_sbox_rom.sv
module aes_sbox_rom #(
    parameter int unsigned NPORTS = 16
) (
    input  logic                   clk,
    input  logic [NPORTS-1:0][7:0] addr_i,
    output logic [NPORTS-1:0][7:0] data_o
);
    localparam int unsigned DEPTH = 256;

    logic [7:0] rom_mem [DEPTH];

    // Contents computed at elaboration, as a memory initialisation image.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom_mem[i[7:0]] = aes_pkg::sbox_calc(i[7:0]);
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [7:0] rd_q;
        always_ff @(posedge clk) begin
            rd_q <= rom_mem[addr_i[p]];
        end
        assign data_o[p] = rd_q;
    end
endmodule

// File: rtl/aes_round_mix.sv
module aes_round_mix
    import aes_pkg::*;
(
    input  state_t sub_i,
    input  state_t key_i,
    input  logic   mix_en_i,
    output state_t next_o
);
    state_t shifted;
    state_t mixed;

    for (genvar c = 0; c < 4; c++) begin : g_col
        // Row rotation: row r takes its byte from column (c + r) mod 4.
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shifted[4*c+r] = sub_i[4*((c+r)%4)+r];
        end

        byte_t a0, a1, a2, a3;
        assign a0 = shifted[4*c+0];
        assign a1 = shifted[4*c+1];
        assign a2 = shifted[4*c+2];
        assign a3 = shifted[4*c+3];

        // Column times {03}x^3+{01}x^2+{01}x+{02}.
        assign mixed[4*c+0] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mixed[4*c+1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
        assign mixed[4*c+2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
        assign mixed[4*c+3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end

    assign next_o = (mix_en_i ? mixed : shifted) ^ key_i;
endmodule

// File: rtl/aes128_round_engine.sv
module aes128_round_engine
    import aes_pkg::*;
#(
    parameter int unsigned ROUNDS = 10,
    localparam int unsigned RIDX_W = $clog2(ROUNDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [127:0]      plaintext_i,
    input  logic [127:0]      round_key_i,
    output logic [RIDX_W-1:0] round_idx_o,
    output logic [127:0]      cipher_o,
    output logic              done_o
);
    localparam logic [RIDX_W-1:0] LAST_RND  = RIDX_W'(ROUNDS);
    localparam logic [RIDX_W-1:0] FIRST_RND = RIDX_W'(1);

    typedef struct packed {
        phase_t              phase;
        logic [RIDX_W-1:0]   round;
        state_t              state;
        state_t              sub;
    } regs_t;

    regs_t  q, d;
    state_t rom_data;
    state_t round_next;
    logic   busy;

    aes_sbox_rom #(
        .NPORTS(STATE_BYTES)
    ) u_sbox (
        .clk   (clk),
        .addr_i(q.state),
        .data_o(rom_data)
    );

    aes_round_mix u_mix (
        .sub_i   (q.sub),
        .key_i   (round_key_i),
        .mix_en_i(q.round != LAST_RND),
        .next_o  (round_next)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE, PH_DONE: begin
                if (load_i) begin
                    d.state = plaintext_i ^ round_key_i;
                    d.round = FIRST_RND;
                    d.phase = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                // Addresses (the state bytes) are now at the ROM.
                d.phase = PH_FETCH;
            end
            PH_FETCH: begin
                // ROM output is valid; register it to cut the memory path.
                d.sub   = rom_data;
                d.phase = PH_ROUND;
            end
            PH_ROUND: begin
                d.state = round_next;
                if (q.round == LAST_RND) begin
                    d.round = '0;
                    d.phase = PH_DONE;
                end else begin
                    d.round = q.round + FIRST_RND;
                    d.phase = PH_ISSUE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, round: '0, state: '0, sub: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.phase == PH_ISSUE) || (q.phase == PH_FETCH) || (q.phase == PH_ROUND);
    assign round_idx_o = q.round;
    assign cipher_o    = q.state;
    assign done_o      = (q.phase == PH_DONE);

    // R1: an accepted load starts round 1 with done cleared.
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_i) |=> (round_idx_o == FIRST_RND && !done_o));

    // R7: the requested key number never exceeds the last round.
    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        round_idx_o <= LAST_RND);

    // R7: completion follows the final round's write-back.
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(round_idx_o) == LAST_RND));

    // R5: the state register holds while the ROM read is outstanding.
    p_state_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ISSUE) |=> $stable(cipher_o));

    // R8: result and flag hold until a load.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && $stable(cipher_o)));

    // R9: a load during a later round never restarts the sequence.
    p_busy_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_i && round_idx_o != FIRST_RND) |=> (round_idx_o != FIRST_RND));
endmodule

// File: tb/aes128_round_engine_bench.sv
module aes128_round_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 40;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         load  = 1'b0;
    logic [127:0] plain = '0;
    logic [127:0] key_bus;
    logic [3:0]   idx;
    logic [127:0] ct;
    logic         done;

    logic [127:0] rk_tab [0:10];
    logic [7:0]   sb [0:255];
    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign key_bus = (idx <= 4'd10) ? rk_tab[idx] : '0;

    aes128_round_engine u_aes128_round_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .plaintext_i(plain),
        .round_key_i(key_bus),
        .round_idx_o(idx),
        .cipher_o   (ct),
        .done_o     (done)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (fmul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ (8'h63 >> i);
            sb[v] = s;
        end
    endtask

    task automatic expand(input logic [127:0] k);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = fmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r <= 10; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] ref_encrypt(input logic [127:0] p);
        logic [127:0] w = p ^ rk_tab[0];
        logic [7:0] s [16];
        logic [7:0] t [16];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int k = 0; k < 16; k++) s[k] = sb[w[127-8*k -: 8]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
            if (rnd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    s[4*c+0] = fmul(2, t[4*c]) ^ fmul(3, t[4*c+1]) ^ t[4*c+2] ^ t[4*c+3];
                    s[4*c+1] = t[4*c] ^ fmul(2, t[4*c+1]) ^ fmul(3, t[4*c+2]) ^ t[4*c+3];
                    s[4*c+2] = t[4*c] ^ t[4*c+1] ^ fmul(2, t[4*c+2]) ^ fmul(3, t[4*c+3]);
                    s[4*c+3] = fmul(3, t[4*c]) ^ t[4*c+1] ^ t[4*c+2] ^ fmul(2, t[4*c+3]);
                end
                for (int k = 0; k < 16; k++) t[k] = s[k];
            end
            for (int k = 0; k < 16; k++) w[127-8*k -: 8] = t[k];
            w = w ^ rk_tab[rnd];
        end
        return w;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Runs one block; a stray load is raised after sample stray_at (-1: none).
    task automatic encrypt_op(input logic [127:0] p, input logic [127:0] k,
                              input int stray_at, output logic [127:0] res);
        expand(k);
        @(negedge clk);
        plain = p;
        load  = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int j = 0; j < 30; j++) begin
            if (j > 0) @(negedge clk);
            check("R7", "round index", 128'(idx), 128'(j/3 + 1));
            check("R7", "done early", 128'(done), 128'(0));
            if (j == 0) check("R1 R8", "start index", 128'(idx), 128'(1));
            if (j == stray_at) begin
                plain = ~p;
                load  = 1'b1;
            end else begin
                load = 1'b0;
            end
        end
        @(negedge clk);
        load  = 1'b0;
        plain = p;
        check("R7", "done at cycle 30", 128'(done), 128'(1));
        check("R7", "index after done", 128'(idx), 128'(0));
        res = ct;
    endtask

    initial begin
        logic [127:0] res;
        logic [127:0] p;
        logic [127:0] k;
        build_sbox();
        expand('0);
        repeat (3) @(negedge clk);
        check("R10", "done in reset", 128'(done), 128'(0));
        check("R10", "index in reset", 128'(idx), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle index", 128'(idx), 128'(0));

        encrypt_op(128'h3243f6a8885a308d313198a2e0370734,
                   128'h2b7e151628aed2a6abf7158809cf4f3c, -1, res);
        check("R2 R3", "known vector one", res, 128'h3925841d02dc09fbdc118597196a0b32);

        // Hold: result and flag unchanged while inputs move without a load.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            plain = 128'(i) * 128'h1111;
            check("R8", "done held", 128'(done), 128'(1));
            check("R8", "cipher held", ct, 128'h3925841d02dc09fbdc118597196a0b32);
        end

        // Load while done is high restarts.
        encrypt_op(128'h00112233445566778899aabbccddeeff,
                   128'h000102030405060708090a0b0c0d0e0f, -1, res);
        check("R3 R8", "known vector two", res, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // Stray loads during busy cycles, including the final round cycle.
        p = 128'h0123456789abcdeffedcba9876543210;
        k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        encrypt_op(p, k, 29, res);
        check("R9", "load in final round", res, ref_encrypt(p));
        encrypt_op(p ^ 128'h5a, k, 4, res);
        check("R9", "load mid block", res, ref_encrypt(p ^ 128'h5a));

        // Reset in the middle of a block.
        expand(k);
        @(negedge clk);
        plain = p;
        load  = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", "index after async reset", 128'(idx), 128'(0));
        check("R10", "done after async reset", 128'(done), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep over generated blocks and keys, plus the all-zero and all-one cases.
        for (int i = 0; i < NVEC + 2; i++) begin
            logic [31:0] u = 32'(i);
            if (i == NVEC) begin
                p = '0;
                k = '0;
            end else if (i == NVEC + 1) begin
                p = '1;
                k = '1;
            end else begin
                p = {u * 32'h9e3779b9, u * 32'h7f4a7c15, ~u, u * u};
                k = {u ^ 32'hdeadbeef, u * 32'h01000193, u << 3, 32'h80000000 >> (u % 32)};
            end
            encrypt_op(p, k, -1, res);
            check("R4 R5 R6", "sweep ciphertext", res, ref_encrypt(p));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule